// File: doc/BRIEF.md
# Cached Vector Register File

The block presents a full set of 32 architectural vector registers to its user while holding only a few of them in on-chip storage slots. The slots work as a fully associative cache. Each slot carries a valid flag, a dirty flag and the 5-bit index of the architectural register it currently holds. Registers that do not fit are kept in a backing memory, and the block moves whole registers in and out of it on demand.

The user issues one access at a time through a valid/ready port. An access is either a full-register read or a full-register write. On a hit the access completes in the same cycle. On a miss the port stalls while a sequencer does three things. It picks a victim slot, taking an empty slot first and the least recently used slot otherwise. It writes the victim back to memory if the victim is dirty. For a read it then loads the wanted register from memory. Once the slot holds the register, the waiting access completes as a hit.

Seen from the port, the block behaves exactly like a flat 32-entry register file. Only the number of cycles an access takes changes. A flush input writes every modified slot back to memory and then empties the store.

Top module: `vreg_cache`

## Requirements
- R1: Each of the 32 architectural registers is selected by a 5-bit index. A read returns the value most recently written to that index, or the backing memory's value if the index was never written, regardless of which slots the register has passed through.
- R2: An access to a register that is present is accepted with ready high in the cycle it is presented. A read drives rsp_valid and the data in that same cycle.
- R3: An access to a register that is absent holds ready low until its slot is prepared. The access then completes in the first cycle ready is high again.
- R4: The victim of a miss is the lowest-numbered empty slot. When no slot is empty, it is the slot whose last accepted access is oldest. Every accepted access refreshes the recency of its slot.
- R5: A dirty victim is written back with one memory write before any fill for the miss. The write goes to address BASE_ADDR + index×(VLEN/8) and carries the slot's contents. A write hit marks the slot dirty.
- R6: A clean victim is dropped without any memory write.
- R7: A read miss loads the register with one memory read from BASE_ADDR + index×(VLEN/8). The loaded slot is clean, so evicting it later needs no write.
- R8: A write miss issues no memory read, because the whole register is overwritten.
- R9: mem_req stays high with mem_we, mem_addr and mem_wdata unchanged until mem_gnt is seen. Read data is taken on a later cycle with mem_rvalid high.
- R10: A flush writes back the dirty slots in ascending slot order and then marks every slot empty. Ready stays low throughout. A later access to any register misses and, with empty slots available, fetches without a write-back.
- R11: After reset all slots are empty, req_ready is high while idle and mem_req is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Access accepted this cycle when high together with req_valid |
| req_write | input | 1 | 1 = full-register write, 0 = read |
| req_idx | input | 5 | Architectural register index |
| req_wdata | input | VLEN | Write data |
| rsp_valid | output | 1 | Read data valid (same cycle as acceptance) |
| rsp_rdata | output | VLEN | Read data |
| flush | input | 1 | Write back all dirty slots, then invalidate all |
| mem_req | output | 1 | Memory request |
| mem_gnt | input | 1 | Memory grant for the current request |
| mem_we | output | 1 | 1 = write-back, 0 = fill read |
| mem_addr | output | ADDR_W | Byte address of the register image |
| mem_wdata | output | VLEN | Write-back data |
| mem_rvalid | input | 1 | Fill data valid |
| mem_rdata | input | VLEN | Fill data |

## Verification
The embedded assertions watch invariants on every cycle:
- no two valid slots hold the same register;
- an accepted access is always a hit;
- a memory write only ever leaves a valid dirty slot;
- a filled slot ends up clean;
- a stalled memory request holds its fields;
- the recency state always keeps exactly one oldest slot.

Victim choice, the order of write-backs against fills, and the flush order and its aftermath only show through the bench's directed scenarios, which compare logged memory traffic against expected sequences. The bench also runs a long random mix whose read data it scores against a shadow register file.

// File: rtl/vrc_pkg.sv
package vrc_pkg;
  typedef enum logic [2:0] {
    SEQ_IDLE,
    SEQ_SPILL,
    SEQ_FILL_REQ,
    SEQ_FILL_WAIT,
    SEQ_INSTALL,
    SEQ_FLUSH
  } seq_state_e;
endpackage

// File: rtl/vrc_lru.sv
// Recency tracker: one age per slot forming a permutation, 0 = newest.
module vrc_lru #(
  parameter int N_SLOTS = 8,
  localparam int SW = $clog2(N_SLOTS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               touch,
  input  logic [SW-1:0]      touch_slot,
  input  logic [N_SLOTS-1:0] slot_valid,
  output logic [SW-1:0]      victim
);
  logic [SW-1:0]      age_q [N_SLOTS];
  logic [SW-1:0]      age_d [N_SLOTS];
  logic [N_SLOTS-1:0] oldest_vec;
  logic               inv_any;
  logic [SW-1:0]      inv_sel;
  logic [SW-1:0]      old_sel;

  always_comb begin
    for (int i = 0; i < N_SLOTS; i++) begin
      age_d[i] = age_q[i];
      if (touch) begin
        if (SW'(i) == touch_slot)
          age_d[i] = '0;
        else if (age_q[i] < age_q[touch_slot])
          age_d[i] = age_q[i] + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_SLOTS; i++) age_q[i] <= SW'(i);
    end else if (touch) begin
      for (int i = 0; i < N_SLOTS; i++) age_q[i] <= age_d[i];
    end
  end

  always_comb begin
    inv_any = 1'b0;
    inv_sel = '0;
    old_sel = '0;
    for (int i = N_SLOTS - 1; i >= 0; i--) begin
      oldest_vec[i] = (age_q[i] == SW'(N_SLOTS - 1));
      if (!slot_valid[i]) begin
        inv_any = 1'b1;
        inv_sel = SW'(i);
      end
    end
    for (int i = 0; i < N_SLOTS; i++)
      if (oldest_vec[i]) old_sel = SW'(i);
    victim = inv_any ? inv_sel : old_sel;
  end

  // R4
  lru_single_oldest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(oldest_vec) == 1);
endmodule

// File: rtl/vrc_seq.sv
// Miss / write-back / fill / flush sequencer.
module vrc_seq
  import vrc_pkg::*;
#(
  parameter int N_SLOTS = 8,
  parameter int IDX_W   = 5,
  localparam int SW = $clog2(N_SLOTS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic [IDX_W-1:0]   req_idx,
  input  logic               hit,
  input  logic               flush,
  input  logic [SW-1:0]      victim,
  input  logic [N_SLOTS-1:0] slot_valid,
  input  logic [N_SLOTS-1:0] slot_dirty,
  input  logic               mem_gnt,
  input  logic               mem_rvalid,
  output logic               ready,
  output logic               mem_req,
  output logic               mem_we,
  output logic [SW-1:0]      cur_slot,
  output logic [IDX_W-1:0]   tgt_idx,
  output logic               spill_done,
  output logic               install,
  output logic               fill_done,
  output logic               clear_all
);
  seq_state_e        state_q, state_d;
  logic [SW-1:0]     cur_q, cur_d;
  logic [IDX_W-1:0]  tgt_q, tgt_d;
  logic              wr_q, wr_d;
  logic              state_en;

  always_comb begin
    state_d    = state_q;
    cur_d      = cur_q;
    tgt_d      = tgt_q;
    wr_d       = wr_q;
    ready      = 1'b0;
    mem_req    = 1'b0;
    mem_we     = 1'b0;
    spill_done = 1'b0;
    install    = 1'b0;
    fill_done  = 1'b0;
    clear_all  = 1'b0;
    unique case (state_q)
      SEQ_IDLE: begin
        ready = !flush && (!req_valid || hit);
        if (flush) begin
          state_d = SEQ_FLUSH;
          cur_d   = '0;
        end else if (req_valid && !hit) begin
          cur_d = victim;
          tgt_d = req_idx;
          wr_d  = req_write;
          if (slot_valid[victim] && slot_dirty[victim]) state_d = SEQ_SPILL;
          else state_d = req_write ? SEQ_INSTALL : SEQ_FILL_REQ;
        end
      end
      SEQ_SPILL: begin
        mem_req = 1'b1;
        mem_we  = 1'b1;
        if (mem_gnt) begin
          spill_done = 1'b1;
          state_d    = wr_q ? SEQ_INSTALL : SEQ_FILL_REQ;
        end
      end
      SEQ_FILL_REQ: begin
        mem_req = 1'b1;
        if (mem_gnt) state_d = SEQ_FILL_WAIT;
      end
      SEQ_FILL_WAIT: begin
        if (mem_rvalid) begin
          fill_done = 1'b1;
          state_d   = SEQ_IDLE;
        end
      end
      SEQ_INSTALL: begin
        install = 1'b1;
        state_d = SEQ_IDLE;
      end
      SEQ_FLUSH: begin
        mem_req = slot_valid[cur_q] && slot_dirty[cur_q];
        mem_we  = mem_req;
        if (!mem_req || mem_gnt) begin
          spill_done = mem_req;
          if (cur_q == SW'(N_SLOTS - 1)) begin
            clear_all = 1'b1;
            state_d   = SEQ_IDLE;
          end else begin
            cur_d = cur_q + 1'b1;
          end
        end
      end
      default: state_d = SEQ_IDLE;
    endcase
  end

  assign state_en = (state_d != state_q) || (cur_d != cur_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      cur_q   <= '0;
      tgt_q   <= '0;
      wr_q    <= 1'b0;
    end else if (state_en) begin
      state_q <= state_d;
      cur_q   <= cur_d;
      tgt_q   <= tgt_d;
      wr_q    <= wr_d;
    end
  end

  assign cur_slot = cur_q;
  assign tgt_idx  = tgt_q;

  // R9
  mem_fields_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_gnt |=> mem_req && $stable(mem_we) && $stable(cur_q) && $stable(tgt_q));
  // R10
  flush_no_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == SEQ_FLUSH |-> !ready);
endmodule

// File: rtl/vreg_cache.sv
// Vector register file with 32 architectural entries cached in N_SLOTS slots.
module vreg_cache #(
  parameter int              N_ARCH    = 32,
  parameter int              N_SLOTS   = 8,
  parameter int              VLEN      = 128,
  parameter int              ADDR_W    = 32,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 32'h0000_1000,
  localparam int IDX_W = $clog2(N_ARCH),
  localparam int SW    = $clog2(N_SLOTS),
  localparam int BYTES = VLEN / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [IDX_W-1:0]  req_idx,
  input  logic [VLEN-1:0]   req_wdata,
  output logic              rsp_valid,
  output logic [VLEN-1:0]   rsp_rdata,
  input  logic              flush,
  output logic              mem_req,
  input  logic              mem_gnt,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [VLEN-1:0]   mem_wdata,
  input  logic              mem_rvalid,
  input  logic [VLEN-1:0]   mem_rdata
);
  logic [VLEN-1:0]    data_q [N_SLOTS];
  logic [IDX_W-1:0]   tag_q  [N_SLOTS];
  logic [N_SLOTS-1:0] valid_q, dirty_q;
  logic [N_SLOTS-1:0] wr_en, fill_en, inst_en, spl_en;
  logic               hit_any, acc, map_dup;
  logic [SW-1:0]      hit_slot, victim, cur_slot;
  logic [IDX_W-1:0]   tgt_idx, addr_idx;
  logic               spill_done, install, fill_done, clear_all;

  always_comb begin
    hit_any  = 1'b0;
    hit_slot = '0;
    for (int i = 0; i < N_SLOTS; i++) begin
      if (valid_q[i] && tag_q[i] == req_idx) begin
        hit_any  = 1'b1;
        hit_slot = SW'(i);
      end
    end
  end

  assign acc = req_valid && req_ready;

  vrc_lru #(.N_SLOTS(N_SLOTS)) u_lru (
    .clk        (clk),
    .rst_n      (rst_n),
    .touch      (acc),
    .touch_slot (hit_slot),
    .slot_valid (valid_q),
    .victim     (victim)
  );

  vrc_seq #(.N_SLOTS(N_SLOTS), .IDX_W(IDX_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_idx    (req_idx),
    .hit        (hit_any),
    .flush      (flush),
    .victim     (victim),
    .slot_valid (valid_q),
    .slot_dirty (dirty_q),
    .mem_gnt    (mem_gnt),
    .mem_rvalid (mem_rvalid),
    .ready      (req_ready),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .cur_slot   (cur_slot),
    .tgt_idx    (tgt_idx),
    .spill_done (spill_done),
    .install    (install),
    .fill_done  (fill_done),
    .clear_all  (clear_all)
  );

  for (genvar g = 0; g < N_SLOTS; g++) begin : g_slot_en
    assign wr_en[g]   = acc && req_write && (hit_slot == SW'(g));
    assign fill_en[g] = fill_done  && (cur_slot == SW'(g));
    assign inst_en[g] = install    && (cur_slot == SW'(g));
    assign spl_en[g]  = spill_done && (cur_slot == SW'(g));
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < N_SLOTS; i++) begin
      if (wr_en[i])        data_q[i] <= req_wdata;
      else if (fill_en[i]) data_q[i] <= mem_rdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
      for (int i = 0; i < N_SLOTS; i++) tag_q[i] <= '0;
    end else begin
      for (int i = 0; i < N_SLOTS; i++) begin
        if (clear_all)                    valid_q[i] <= 1'b0;
        else if (fill_en[i] || inst_en[i]) valid_q[i] <= 1'b1;
        if (clear_all)                    dirty_q[i] <= 1'b0;
        else if (wr_en[i])                dirty_q[i] <= 1'b1;
        else if (fill_en[i] || inst_en[i] || spl_en[i]) dirty_q[i] <= 1'b0;
        if (fill_en[i] || inst_en[i])     tag_q[i] <= tgt_idx;
      end
    end
  end

  assign rsp_valid = acc && !req_write;
  assign rsp_rdata = data_q[hit_slot];
  assign addr_idx  = mem_we ? tag_q[cur_slot] : tgt_idx;
  assign mem_addr  = BASE_ADDR + ADDR_W'(addr_idx) * ADDR_W'(BYTES);
  assign mem_wdata = data_q[cur_slot];

  always_comb begin
    map_dup = 1'b0;
    for (int i = 0; i < N_SLOTS; i++)
      for (int j = i + 1; j < N_SLOTS; j++)
        if (valid_q[i] && valid_q[j] && tag_q[i] == tag_q[j]) map_dup = 1'b1;
  end

  // R1
  map_unique_chk: assert property (@(posedge clk) disable iff (!rst_n) !map_dup);
  // R2
  accept_is_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |-> hit_any);
  // R5
  write_marks_dirty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && req_write |=> dirty_q[$past(hit_slot)]);
  // R6
  spill_only_dirty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> valid_q[cur_slot] && dirty_q[cur_slot]);
  // R7
  fill_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_done |=> valid_q[$past(cur_slot)] && !dirty_q[$past(cur_slot)]);
  // R9
  mem_addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_gnt |=> mem_req && $stable(mem_addr) && $stable(mem_wdata));
endmodule

// File: tb/vreg_cache_test.sv
`timescale 1ns/1ps
module vreg_cache_test;
  localparam int          VLEN = 128;
  localparam logic [31:0] BASE = 32'h0000_1000;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic             rst_n;
  logic             req_valid, req_ready, req_write, rsp_valid, flush;
  logic [4:0]       req_idx;
  logic [VLEN-1:0]  req_wdata, rsp_rdata, mem_wdata, mem_rdata;
  logic             mem_req, mem_gnt, mem_we, mem_rvalid;
  logic [31:0]      mem_addr;

  vreg_cache uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_idx(req_idx), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .flush(flush),
    .mem_req(mem_req), .mem_gnt(mem_gnt), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  int gnt_delay = 0;
  int last_wait = 0;
  logic [VLEN-1:0] shadow  [32];
  logic [VLEN-1:0] mem_arr [32];
  logic [VLEN-1:0] exp_q [$];
  logic            log_we   [$];
  logic [31:0]     log_addr [$];
  logic [VLEN-1:0] log_data [$];

  function automatic logic [VLEN-1:0] pat(int i, int s);
    return {32'(i), 32'(s), 32'hC0DE_0000 + 32'(i), 32'(s * 7 + i)};
  endfunction

  task automatic check(bit ok, string rq, string what, logic [VLEN-1:0] act, logic [VLEN-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  task automatic clear_log();
    log_we.delete(); log_addr.delete(); log_data.delete();
  endtask

  task automatic exp_op(int k, bit we, int idx, logic [VLEN-1:0] d, string rq);
    if (k >= log_addr.size()) begin
      check(1'b0, rq, "missing memory op", VLEN'(log_addr.size()), VLEN'(k + 1));
    end else begin
      check(log_we[k] == we, rq, "op direction", VLEN'(log_we[k]), VLEN'(we));
      check(log_addr[k] == BASE + 32'(idx * 16), rq, "op address", VLEN'(log_addr[k]),
            VLEN'(BASE + 32'(idx * 16)));
      if (we) check(log_data[k] == d, rq, "write-back data", log_data[k], d);
    end
  endtask

  task automatic access(bit wr, int idx, logic [VLEN-1:0] d);
    @(posedge clk); #1;
    req_valid = 1'b1; req_write = wr; req_idx = 5'(idx); req_wdata = d;
    if (!wr) exp_q.push_back(shadow[idx]);
    last_wait = 0;
    @(negedge clk);
    while (!req_ready) begin last_wait++; @(negedge clk); end
    if (wr) shadow[idx] = d;
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic do_flush();
    @(posedge clk); #1 flush = 1'b1;
    @(posedge clk); #1 flush = 1'b0;
    @(negedge clk);
    check(!req_ready, "R10", "ready during flush", VLEN'(req_ready), '0);
    while (!req_ready) @(negedge clk);
  endtask

  // backing memory model with configurable grant delay
  initial begin
    bit rd_pend = 1'b0;
    int rd_cnt = 0;
    int rd_idx = 0;
    int wcnt = 0;
    mem_gnt = 1'b0; mem_rvalid = 1'b0; mem_rdata = '0;
    forever begin
      @(posedge clk); #1;
      mem_gnt = 1'b0; mem_rvalid = 1'b0;
      if (rd_pend) begin
        if (rd_cnt == 0) begin
          mem_rvalid = 1'b1; mem_rdata = mem_arr[rd_idx]; rd_pend = 1'b0;
        end else rd_cnt--;
      end else if (mem_req && rst_n) begin
        wcnt++;
        if (wcnt > gnt_delay) begin
          int idx;
          mem_gnt = 1'b1; wcnt = 0;
          idx = int'((mem_addr - BASE) >> 4);
          log_we.push_back(mem_we); log_addr.push_back(mem_addr); log_data.push_back(mem_wdata);
          if (mem_we) mem_arr[idx] = mem_wdata;
          else begin rd_pend = 1'b1; rd_cnt = 1; rd_idx = idx; end
        end
      end
    end
  end

  // scoreboard monitor: R1 read data, R2 same-cycle response
  always @(negedge clk) begin
    if (rst_n && req_valid && req_ready && !req_write) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R1", "unexpected read response", rsp_rdata, '0);
      end else begin
        logic [VLEN-1:0] e;
        e = exp_q.pop_front();
        check(rsp_valid, "R2", "rsp_valid on accept", VLEN'(rsp_valid), VLEN'(1));
        check(rsp_rdata == e, "R1", "read data", rsp_rdata, e);
      end
    end
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] lf;
    for (int i = 0; i < 32; i++) begin
      mem_arr[i] = {4{32'hA500_0000 | 32'(i)}};
      shadow[i]  = mem_arr[i];
    end
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_idx = '0; req_wdata = '0; flush = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check(req_ready, "R11", "ready after reset", VLEN'(req_ready), VLEN'(1));
    check(!mem_req, "R11", "mem_req after reset", VLEN'(mem_req), '0);

    // fill the empty slots with writes: no memory traffic
    gnt_delay = 0;
    clear_log();
    for (int i = 0; i < 8; i++) access(1'b1, i, pat(i, 1));
    check(log_addr.size() == 0, "R8", "ops for writes into empty slots", VLEN'(log_addr.size()), '0);
    access(1'b0, 3, '0);
    check(last_wait == 0, "R2", "hit stall cycles", VLEN'(last_wait), '0);

    // LRU dirty victim (reg0) is spilled
    clear_log();
    access(1'b1, 8, pat(8, 1));
    check(last_wait > 0, "R3", "miss stalls ready", VLEN'(last_wait), VLEN'(1));
    check(log_addr.size() == 1, "R8", "op count write miss", VLEN'(log_addr.size()), VLEN'(1));
    exp_op(0, 1'b1, 0, pat(0, 1), "R4");

    // read miss: spill reg1 then fill reg0, with slow grants
    gnt_delay = 2;
    clear_log();
    access(1'b0, 0, '0);
    check(log_addr.size() == 2, "R9", "op count read miss", VLEN'(log_addr.size()), VLEN'(2));
    exp_op(0, 1'b1, 1, pat(1, 1), "R5");
    exp_op(1, 1'b0, 0, '0, "R7");

    access(1'b0, 0, '0);
    check(last_wait == 0, "R2", "refetched reg hits", VLEN'(last_wait), '0);
    clear_log();
    access(1'b0, 9, '0);
    exp_op(0, 1'b1, 2, pat(2, 1), "R5");
    exp_op(1, 1'b0, 9, '0, "R7");

    // make the clean reg0 the oldest, then miss: no write-back
    gnt_delay = 1;
    foreach (shadow[k]) if (k inside {4, 5, 6, 7, 3, 8, 9}) begin end
    access(1'b0, 4, '0); access(1'b0, 5, '0); access(1'b0, 6, '0); access(1'b0, 7, '0);
    access(1'b0, 3, '0); access(1'b0, 8, '0); access(1'b0, 9, '0);
    check(last_wait == 0, "R4", "touch hits", VLEN'(last_wait), '0);
    clear_log();
    access(1'b0, 10, '0);
    check(log_addr.size() == 1, "R6", "clean victim op count", VLEN'(log_addr.size()), VLEN'(1));
    exp_op(0, 1'b0, 10, '0, "R6");

    // flush: dirty slots 0(r8),3(r3),4..7(r4..r7) in slot order
    clear_log();
    do_flush();
    check(log_addr.size() == 6, "R10", "flush op count", VLEN'(log_addr.size()), VLEN'(6));
    exp_op(0, 1'b1, 8, pat(8, 1), "R10");
    exp_op(1, 1'b1, 3, pat(3, 1), "R10");
    for (int i = 4; i < 8; i++) exp_op(i - 2, 1'b1, i, pat(i, 1), "R10");
    clear_log();
    access(1'b0, 3, '0);
    check(log_addr.size() == 1, "R10", "post-flush miss op count", VLEN'(log_addr.size()), VLEN'(1));
    exp_op(0, 1'b0, 3, '0, "R10");
    clear_log();
    access(1'b1, 20, pat(20, 2));
    check(log_addr.size() == 0, "R8", "write miss without fill", VLEN'(log_addr.size()), '0);

    // random mix scored against shadow
    lf = 32'h1234_5678;
    for (int n = 0; n < 400; n++) begin
      lf ^= lf << 13; lf ^= lf >> 17; lf ^= lf << 5;
      gnt_delay = int'(lf[9:8]) % 3;
      access(lf[0], int'(lf[6:2]), pat(int'(lf[6:2]), n + 3));
    end
    do_flush();
    for (int i = 0; i < 32; i++)
      check(mem_arr[i] == shadow[i], "R1", "memory image after flush", mem_arr[i], shadow[i]);
    repeat (2) @(negedge clk);
    check(exp_q.size() == 0, "R1", "pending expected reads", VLEN'(exp_q.size()), '0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule